// File: doc/BRIEF.md
# Register Write Sequence Gatherer

This block sits between a host that issues register update requests and two consumers: a simple register bus, and a command queue served by a separate execution engine. Each request carries an address, a modify mask and a modify value. When no gather window is open, a request becomes an immediate read-modify-write on the register bus. The block reads the old word and writes back `(old & ~mask) | value`. When the mask covers every bit, the read is skipped and the value is written as is.

A start pulse opens a gather window. Requests that arrive inside the window are not sent to the bus. They are packed as (address, mask, value) triples into a fixed-size record, and the record is offered on a valid/ready push port tagged with a command type and a payload length in bytes. A record is flushed when a request finds it already full, or when the host pulses submit. After the final record of a window has been taken, the window closes and a one-cycle execute pulse tells the consumer to run the queue.

A request that is still waiting when submit arrives is held until the window has closed, and then takes the direct path. Opening a window while one is already open is a caller error and sets a sticky error flag.

Top module: `rseq_gather`

## Requirements
- R1: A `gather_start` pulse sampled while the window is closed opens it from the next cycle on. A `gather_start` sampled while the window is open leaves the window open and sets `seq_err` from the next cycle until reset.
- R2: Inside the window, accepted requests fill record slots in arrival order. Slot i sits at `cmd_payload[i*96 +: 96]`, with the address in bits 31:0, the mask in bits 63:32 and the value in bits 95:64 of the slot.
- R3: A record holds at most 5 triples. A request that arrives while 5 are stored raises `cmd_valid` for that record and is stalled (`req_ready` low) until the record has been taken. It then becomes slot 0 of a new record.
- R4: Every record is offered with `cmd_type` = 1 (read-modify-write) and `cmd_bytes` = 12 × `cmd_count`.
- R5: After each accepted record the triple count restarts at zero, so the next request fills slot 0.
- R6: Submit inside the window with triples pending offers them as a record two cycles after the submit cycle. In the cycle after that record is taken, the window is closed and `exec_pulse` is high for exactly one cycle.
- R7: Submit inside the window with no triples pending offers no record. The window closes and `exec_pulse` is high for one cycle, two cycles after the submit cycle.
- R8: While `cmd_valid` is high and `cmd_ready` is low, the offered record (count, bytes, payload) does not change.
- R9: With the window closed, an accepted request drives a read (`bus_req`=1, `bus_we`=0) at its address, then a write of `(rdata & ~mask) | value` to the same address. `req_ready` stays low until the write is acknowledged, and address and direction hold while `bus_ack` is low.
- R10: A direct request whose mask is all ones skips the read and writes `value` directly.
- R11: Submit while the window is closed has no effect: no record and no `exec_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gather_start | input | 1 | Pulse: open the gather window |
| submit | input | 1 | Pulse: flush and close the window, then execute |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken this cycle when high with req_valid |
| req_addr | input | 32 | Register address |
| req_mask | input | 32 | Bits to modify |
| req_value | input | 32 | New bit values |
| seq_err | output | 1 | Sticky nested-start error |
| exec_pulse | output | 1 | One-cycle execute request to the consumer |
| cmd_valid | output | 1 | Record offered |
| cmd_ready | input | 1 | Consumer takes the record |
| cmd_type | output | 4 | Command type code (1 = read-modify-write) |
| cmd_count | output | 3 | Triples in the record |
| cmd_bytes | output | 6 | Payload length in bytes |
| cmd_payload | output | 480 | Packed triples, slot 0 in the low bits |
| bus_req | output | 1 | Register bus access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | 32 | Register bus address |
| bus_wdata | output | 32 | Register bus write data |
| bus_rdata | input | 32 | Register bus read data |
| bus_ack | input | 1 | Access complete |

## Verification
A stale triple count shows up at the push port on the next record. The port would show a wrong `cmd_count` or `cmd_bytes`, or a new triple landing in a non-zero slot, in the cycle the record is offered. A window flag stuck open or closed is visible within one or two cycles: a request either reaches the register bus when it should have been packed, or is packed when it should have gone to the bus. A wrong `exec_pulse` timing also appears at once. A direct engine that leaves its state wrongly is caught in the next bus beat, through a missing read, a wrong merge value in `bus_wdata`, or `req_ready` rising before the write acknowledge.

// File: rtl/rseq_pkg.sv
// Shared definitions for the register write sequence gatherer.
package rseq_pkg;
    // Command type code carried by every gathered record.
    localparam int unsigned RMW_CODE = 1;

    // States of the direct read-modify-write engine.
    typedef enum logic [1:0] {
        DIR_IDLE  = 2'd0,
        DIR_READ  = 2'd1,
        DIR_WRITE = 2'd2
    } dir_state_t;
endpackage

// File: rtl/rseq_window.sv
// Gather window control.
// Tracks whether a gather window is open, records a pending submit,
// and closes the window either directly (nothing stored) or after the
// closing record has been taken by the consumer. Flags nested starts.
// Assumes start and submit are single-cycle pulses.
module rseq_window (
    input  logic clk,
    input  logic rst_n,
    input  logic gather_start,
    input  logic submit,
    input  logic pk_busy,
    input  logic pk_empty,
    input  logic close_done,
    output logic win_open,
    output logic sub_pend,
    output logic close_go,
    output logic seq_err,
    output logic exec_pulse
);
    // Ask the packer for a closing flush once it is free and holds data.
    assign close_go = sub_pend && !pk_busy && !pk_empty;

    // Window, pending-submit, error and execute registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_open   <= 1'b0;
            sub_pend   <= 1'b0;
            seq_err    <= 1'b0;
            exec_pulse <= 1'b0;
        end else begin
            exec_pulse <= 1'b0;
            if (gather_start) begin
                if (win_open) seq_err  <= 1'b1;
                else          win_open <= 1'b1;
            end
            if (submit && win_open) sub_pend <= 1'b1;
            if ((sub_pend && !pk_busy && pk_empty) || close_done) begin
                win_open   <= 1'b0;
                sub_pend   <= 1'b0;
                exec_pulse <= 1'b1;
            end
        end
    end

    // R1
    nested_start_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_open && gather_start) |=> seq_err);
    // R6
    exec_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_pulse |-> !win_open);
    // R7
    exec_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_pulse |=> !exec_pulse);
endmodule

// File: rtl/rseq_packer.sv
// Record packer.
// Stores gathered triples in a flat slot array and offers the record on a
// valid/ready port. A flush starts on a full record met by a new request,
// or on the closing request from the window control. The record is frozen
// while offered. Assumes push is only asserted when pk_ready is high.
module rseq_packer #(
    parameter int unsigned AW          = 32,
    parameter int unsigned DW          = 32,
    parameter int unsigned MAX_TRIPLES = 5,
    parameter int unsigned TRIP_W      = AW + 2 * DW,
    parameter int unsigned CNT_W       = $clog2(MAX_TRIPLES + 1),
    parameter int unsigned BYTES_W     = $clog2(MAX_TRIPLES * (TRIP_W / 8) + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          win_open,
    input  logic                          sub_pend,
    input  logic                          dir_idle,
    input  logic                          req_valid,
    input  logic                          push,
    input  logic [AW-1:0]                 req_addr,
    input  logic [DW-1:0]                 req_mask,
    input  logic [DW-1:0]                 req_value,
    input  logic                          close_go,
    input  logic                          cmd_ready,
    output logic                          pk_ready,
    output logic                          pk_busy,
    output logic                          pk_empty,
    output logic                          close_done,
    output logic                          cmd_valid,
    output logic [CNT_W-1:0]              cmd_count,
    output logic [BYTES_W-1:0]            cmd_bytes,
    output logic [MAX_TRIPLES*TRIP_W-1:0] cmd_payload
);
    localparam int unsigned TRIP_BYTES = TRIP_W / 8;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(MAX_TRIPLES);

    logic [CNT_W-1:0] cnt_q;
    logic             valid_q;
    logic             close_q;
    logic             full;
    logic             full_go;
    logic             taken;

    assign full     = (cnt_q == FULL_CNT);
    assign taken    = valid_q && cmd_ready;
    assign full_go  = win_open && req_valid && dir_idle && !valid_q && full && !sub_pend;
    assign pk_ready = !valid_q && !full && !sub_pend;
    assign pk_busy  = valid_q;
    assign pk_empty = (cnt_q == '0);
    assign close_done = taken && close_q;

    assign cmd_valid = valid_q;
    assign cmd_count = cnt_q;
    assign cmd_bytes = BYTES_W'(cnt_q) * BYTES_W'(TRIP_BYTES);

    // Count and flush control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            valid_q <= 1'b0;
            close_q <= 1'b0;
        end else begin
            if (taken) begin
                valid_q <= 1'b0;
                close_q <= 1'b0;
                cnt_q   <= '0;
            end else if (!valid_q && close_go) begin
                valid_q <= 1'b1;
                close_q <= 1'b1;
            end else if (full_go) begin
                valid_q <= 1'b1;
                close_q <= 1'b0;
            end
            if (push) cnt_q <= cnt_q + 1'b1;
        end
    end

    // One register per slot, loaded when the count points at it.
    for (genvar s = 0; s < MAX_TRIPLES; s++) begin : g_slot
        logic [TRIP_W-1:0] slot_q;
        // Capture the triple for slot s.
        always_ff @(posedge clk) begin
            if (!rst_n)                            slot_q <= '0;
            else if (push && cnt_q == CNT_W'(s))   slot_q <= {req_value, req_mask, req_addr};
        end
        assign cmd_payload[s*TRIP_W +: TRIP_W] = slot_q;
    end

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_CNT);
    // R3
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !valid_q) |-> !pk_ready);
    // R8
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q && !cmd_ready) |=> (valid_q && $stable(cmd_payload) && $stable(cnt_q)));
    // R7
    no_empty_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> (cnt_q != '0));
    // R5
    cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> (cnt_q == '0));
endmodule

// File: rtl/rseq_direct.sv
// Direct read-modify-write engine.
// Takes one request at a time, reads the register, merges under the mask
// and writes back. An all-ones mask skips the read. Assumes bus_ack is a
// one-cycle acknowledge and bus_rdata is valid with it.
module rseq_direct #(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] mask,
    input  logic [DW-1:0] value,
    output logic          idle,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ack
);
    import rseq_pkg::*;

    dir_state_t    state_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] mask_q;
    logic [DW-1:0] val_q;
    logic [DW-1:0] wdata_q;

    assign idle      = (state_q == DIR_IDLE);
    assign bus_req   = (state_q != DIR_IDLE);
    assign bus_we    = (state_q == DIR_WRITE);
    assign bus_addr  = addr_q;
    assign bus_wdata = wdata_q;

    // Sequence the read and write beats of one request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DIR_IDLE;
            addr_q  <= '0;
            mask_q  <= '0;
            val_q   <= '0;
            wdata_q <= '0;
        end else begin
            case (state_q)
                DIR_IDLE: begin
                    if (start) begin
                        addr_q <= addr;
                        mask_q <= mask;
                        val_q  <= value;
                        if (&mask) begin
                            wdata_q <= value;
                            state_q <= DIR_WRITE;
                        end else begin
                            state_q <= DIR_READ;
                        end
                    end
                end
                DIR_READ: begin
                    if (bus_ack) begin
                        wdata_q <= (bus_rdata & ~mask_q) | val_q;
                        state_q <= DIR_WRITE;
                    end
                end
                DIR_WRITE: begin
                    if (bus_ack) state_q <= DIR_IDLE;
                end
                default: state_q <= DIR_IDLE;
            endcase
        end
    end

    // R9
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));
    // R9
    rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_ack) |=> (bus_req && bus_we));
    // R10
    skip_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && idle && (&mask)) |=> bus_we);
endmodule

// File: rtl/rseq_gather.sv
// Register write sequence gatherer, top level.
// Routes each request either to the direct engine (window closed) or to
// the packer (window open), and holds requests while the direct engine is
// busy so that bus order follows request order.
module rseq_gather #(
    parameter int unsigned AW          = 32,
    parameter int unsigned DW          = 32,
    parameter int unsigned MAX_TRIPLES = 5,
    parameter int unsigned TYPE_W      = 4,
    parameter int unsigned TRIP_W      = AW + 2 * DW,
    parameter int unsigned CNT_W       = $clog2(MAX_TRIPLES + 1),
    parameter int unsigned BYTES_W     = $clog2(MAX_TRIPLES * (TRIP_W / 8) + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          gather_start,
    input  logic                          submit,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [AW-1:0]                 req_addr,
    input  logic [DW-1:0]                 req_mask,
    input  logic [DW-1:0]                 req_value,
    output logic                          seq_err,
    output logic                          exec_pulse,
    output logic                          cmd_valid,
    input  logic                          cmd_ready,
    output logic [TYPE_W-1:0]             cmd_type,
    output logic [CNT_W-1:0]              cmd_count,
    output logic [BYTES_W-1:0]            cmd_bytes,
    output logic [MAX_TRIPLES*TRIP_W-1:0] cmd_payload,
    output logic                          bus_req,
    output logic                          bus_we,
    output logic [AW-1:0]                 bus_addr,
    output logic [DW-1:0]                 bus_wdata,
    input  logic [DW-1:0]                 bus_rdata,
    input  logic                          bus_ack
);
    logic win_open, sub_pend, close_go, close_done;
    logic pk_ready, pk_busy, pk_empty;
    logic dir_idle, dir_start, pk_push;

    assign req_ready = dir_idle && (!win_open || pk_ready);
    assign dir_start = req_valid && req_ready && !win_open;
    assign pk_push   = req_valid && req_ready && win_open;
    assign cmd_type  = TYPE_W'(rseq_pkg::RMW_CODE);

    rseq_window u_window (
        .clk          (clk),
        .rst_n        (rst_n),
        .gather_start (gather_start),
        .submit       (submit),
        .pk_busy      (pk_busy),
        .pk_empty     (pk_empty),
        .close_done   (close_done),
        .win_open     (win_open),
        .sub_pend     (sub_pend),
        .close_go     (close_go),
        .seq_err      (seq_err),
        .exec_pulse   (exec_pulse)
    );

    rseq_packer #(
        .AW (AW), .DW (DW), .MAX_TRIPLES (MAX_TRIPLES),
        .TRIP_W (TRIP_W), .CNT_W (CNT_W), .BYTES_W (BYTES_W)
    ) u_packer (
        .clk         (clk),
        .rst_n       (rst_n),
        .win_open    (win_open),
        .sub_pend    (sub_pend),
        .dir_idle    (dir_idle),
        .req_valid   (req_valid),
        .push        (pk_push),
        .req_addr    (req_addr),
        .req_mask    (req_mask),
        .req_value   (req_value),
        .close_go    (close_go),
        .cmd_ready   (cmd_ready),
        .pk_ready    (pk_ready),
        .pk_busy     (pk_busy),
        .pk_empty    (pk_empty),
        .close_done  (close_done),
        .cmd_valid   (cmd_valid),
        .cmd_count   (cmd_count),
        .cmd_bytes   (cmd_bytes),
        .cmd_payload (cmd_payload)
    );

    rseq_direct #(.AW (AW), .DW (DW)) u_direct (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (dir_start),
        .addr      (req_addr),
        .mask      (req_mask),
        .value     (req_value),
        .idle      (dir_idle),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ack   (bus_ack)
    );

    // R9
    no_bus_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_open && dir_idle) |=> !($rose(bus_req)));
    // R11
    closed_submit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_open && !cmd_valid) |=> !exec_pulse);
endmodule

// File: tb/rseq_gather_tb_top.sv
`timescale 1ns/1ps
module rseq_gather_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         gather_start = 1'b0;
    logic         submit = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [31:0]  req_addr = '0;
    logic [31:0]  req_mask = '0;
    logic [31:0]  req_value = '0;
    logic         seq_err;
    logic         exec_pulse;
    logic         cmd_valid;
    logic         cmd_ready = 1'b1;
    logic [3:0]   cmd_type;
    logic [2:0]   cmd_count;
    logic [5:0]   cmd_bytes;
    logic [479:0] cmd_payload;
    logic         bus_req;
    logic         bus_we;
    logic [31:0]  bus_addr;
    logic [31:0]  bus_wdata;
    logic [31:0]  bus_rdata = '0;
    logic         bus_ack = 1'b0;

    always #4 clk = ~clk;

    rseq_gather dut_i (
        .clk(clk), .rst_n(rst_n), .gather_start(gather_start), .submit(submit),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_mask(req_mask), .req_value(req_value), .seq_err(seq_err),
        .exec_pulse(exec_pulse), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_type(cmd_type), .cmd_count(cmd_count), .cmd_bytes(cmd_bytes),
        .cmd_payload(cmd_payload), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack)
    );

    int errs = 0;
    int checks = 0;
    int cyc = 0;
    int rec_seen = 0;
    int exec_seen = 0;
    int rdy_mode = 0;
    int bwait = 0;
    bit armed = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [31:0] mem [logic [31:0]];

    // reference model state
    bit m_open, m_pend, m_err, m_exec, m_busy, m_close, m_skip;
    int m_d;
    logic [31:0] m_daddr, m_dmask, m_dval, m_wdata;
    logic [95:0] m_rec[$];

    task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit model_ready();
        if (m_d != 0) return 1'b0;
        if (!m_open) return 1'b1;
        return !m_busy && !m_pend && (m_rec.size() < 5);
    endfunction

    function automatic logic [31:0] rd_word(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return a ^ 32'hA5A5_0F0F;
    endfunction

    // Behavioural reference model, advanced on every clock edge.
    always @(posedge clk) begin
        bit acc, hs, full_go, close_go, was_empty;
        bit n_open, n_pend, n_err, n_busy, n_close, n_exec;
        cyc++;
        if (cyc > 100000) begin
            errs++; checks++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
        if (!rst_n) begin
            m_open = 0; m_pend = 0; m_err = 0; m_exec = 0; m_busy = 0; m_close = 0;
            m_d = 0; m_skip = 0; m_daddr = '0; m_dmask = '0; m_dval = '0; m_wdata = '0;
            m_rec.delete();
            armed = 1;
        end else begin
            acc       = req_valid && model_ready();
            hs        = m_busy && cmd_ready;
            was_empty = (m_rec.size() == 0);
            full_go   = m_open && req_valid && (m_d == 0) && !m_busy && !m_pend && (m_rec.size() == 5);
            close_go  = m_pend && !m_busy && !was_empty;
            n_open = m_open; n_pend = m_pend; n_err = m_err; n_exec = 0;
            n_busy = m_busy; n_close = m_close;
            if (gather_start) begin
                if (m_open) n_err = 1; else n_open = 1;
            end
            if (submit && m_open) n_pend = 1;
            if (acc && !m_open) begin
                m_daddr = req_addr; m_dmask = req_mask; m_dval = req_value;
                if (req_mask == 32'hFFFF_FFFF) begin m_d = 2; m_wdata = req_value; m_skip = 1; end
                else begin m_d = 1; m_skip = 0; end
            end else if (m_d == 1 && bus_ack) begin
                m_wdata = (bus_rdata & ~m_dmask) | m_dval; m_d = 2;
            end else if (m_d == 2 && bus_ack) begin
                m_d = 0;
            end
            if (acc && m_open) m_rec.push_back({req_value, req_mask, req_addr});
            if (hs) begin
                m_rec.delete(); n_busy = 0; n_close = 0;
                if (m_close) begin n_open = 0; n_pend = 0; n_exec = 1; end
            end else if (!m_busy && close_go) begin
                n_busy = 1; n_close = 1;
            end else if (full_go) begin
                n_busy = 1; n_close = 0;
            end
            if (m_pend && !m_busy && was_empty) begin n_open = 0; n_pend = 0; n_exec = 1; end
            m_open = n_open; m_pend = n_pend; m_err = n_err; m_exec = n_exec;
            m_busy = n_busy; m_close = n_close;
        end
    end

    // Compare every output with the model, away from the active edge.
    always @(negedge clk) begin
        if (armed) begin
            if (exec_pulse) exec_seen++;
            chk("R3 req_ready", 96'(req_ready), 96'(model_ready()));
            chk("R1 seq_err", 96'(seq_err), 96'(m_err));
            chk("R6/R7/R11 exec_pulse", 96'(exec_pulse), 96'(m_exec));
            chk("R6 cmd_valid", 96'(cmd_valid), 96'(m_busy));
            chk("R9 bus_req", 96'(bus_req), 96'(m_d != 0));
            chk("R9/R10 bus_we", 96'(bus_we), 96'(m_d == 2));
            if (m_d != 0) chk("R9 bus_addr", 96'(bus_addr), 96'(m_daddr));
            if (m_d == 2) chk(m_skip ? "R10 bus_wdata" : "R9 bus_wdata", 96'(bus_wdata), 96'(m_wdata));
            if (m_busy) begin
                chk("R4 cmd_type", 96'(cmd_type), 96'd1);
                chk("R5 cmd_count", 96'(cmd_count), 96'(m_rec.size()));
                chk("R4 cmd_bytes", 96'(cmd_bytes), 96'(12 * m_rec.size()));
                for (int i = 0; i < m_rec.size(); i++)
                    chk("R2/R8 payload slot", cmd_payload[i*96 +: 96], m_rec[i]);
            end
        end
    end

    // Consumer ready pattern and register bus responder.
    always @(negedge clk) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        case (rdy_mode)
            0: cmd_ready = 1'b1;
            1: cmd_ready = lfsr[0];
            default: cmd_ready = 1'b0;
        endcase
        if (cmd_valid && cmd_ready) rec_seen++;
        if (bus_ack) bus_ack = 1'b0;
        else if (bus_req) begin
            if (bwait > 0) bwait--;
            else begin
                bus_ack = 1'b1;
                if (bus_we) mem[bus_addr] = bus_wdata;
                else bus_rdata = rd_word(bus_addr);
                bwait = int'(lfsr[2:1]) % 3;
            end
        end
    end

    task automatic pulse_start();
        @(negedge clk); gather_start = 1'b1;
        @(negedge clk); gather_start = 1'b0;
    endtask

    task automatic pulse_submit();
        @(negedge clk); submit = 1'b1;
        @(negedge clk); submit = 1'b0;
    endtask

    task automatic send_req(input logic [31:0] a, input logic [31:0] m, input logic [31:0] v);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_mask = m; req_value = v;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
        while (cmd_valid || bus_req) @(negedge clk);
        repeat (3) @(negedge clk);
        @(posedge clk);
    endtask

    initial begin
        int r0, e0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset seq_err", 96'(seq_err), 96'd0);
        chk("R6 reset cmd_valid", 96'(cmd_valid), 96'd0);
        chk("R9 reset req_ready", 96'(req_ready), 96'd1);

        // direct path: partial mask, full mask, then partial on written data
        send_req(32'h100, 32'h0000_FF00, 32'h0000_3400);
        send_req(32'h100, 32'hFFFF_FFFF, 32'h1234_5678);
        send_req(32'h100, 32'h0000_00F0, 32'h0000_0050);
        send_req(32'h204, 32'h0, 32'h8000_0001);
        settle();
        chk("R10 mem after writes", 96'(mem[32'h100]), 96'h1234_5658);

        // three gathered, then submit
        r0 = rec_seen; e0 = exec_seen;
        pulse_start();
        for (int i = 0; i < 3; i++) send_req(32'h300 + i*4, 32'h0F << i, 32'h3 << i);
        pulse_submit();
        settle();
        chk("R6 records after submit", 96'(rec_seen - r0), 96'd1);
        chk("R6 exec after submit", 96'(exec_seen - e0), 96'd1);

        // seven gathered with a wavering consumer
        rdy_mode = 1;
        r0 = rec_seen;
        pulse_start();
        for (int i = 0; i < 7; i++) send_req(32'h400 + i, ~(32'h1 << i), i * 32'h11);
        pulse_submit();
        settle();
        chk("R5 records for seven", 96'(rec_seen - r0), 96'd2);

        // exactly five, then submit: a single record
        rdy_mode = 0;
        r0 = rec_seen;
        pulse_start();
        for (int i = 0; i < 5; i++) send_req(32'h500 + i, 32'hFF, 32'hA0 + i);
        pulse_submit();
        settle();
        chk("R3 records for five", 96'(rec_seen - r0), 96'd1);

        // full record with a stalled consumer blocks the sixth request
        rdy_mode = 2;
        pulse_start();
        for (int i = 0; i < 5; i++) send_req(32'h600 + i, 32'hF0, 32'h10 + i);
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h6FF; req_mask = 32'h3; req_value = 32'h2;
        repeat (4) @(negedge clk);
        #1;
        chk("R3 stalled req_ready", 96'(req_ready), 96'd0);
        chk("R3 stalled cmd_count", 96'(cmd_count), 96'd5);
        rdy_mode = 0;
        while (!req_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk("R5 fresh record slot 0 count", 96'(cmd_valid ? 3'd7 : cmd_count), 96'd1);
        pulse_submit();
        settle();

        // empty submit: execute without a record
        r0 = rec_seen; e0 = exec_seen;
        pulse_start();
        pulse_submit();
        settle();
        chk("R7 no record on empty submit", 96'(rec_seen - r0), 96'd0);
        chk("R7 exec on empty submit", 96'(exec_seen - e0), 96'd1);

        // submit with the window closed
        r0 = rec_seen; e0 = exec_seen;
        pulse_submit();
        settle();
        chk("R11 no exec when closed", 96'(exec_seen - e0), 96'd0);
        chk("R11 no record when closed", 96'(rec_seen - r0), 96'd0);

        // nested start
        pulse_start();
        send_req(32'h700, 32'h1, 32'h1);
        pulse_start();
        @(negedge clk);
        chk("R1 nested start flag", 96'(seq_err), 96'd1);
        pulse_submit();
        settle();

        // long mixed run
        rdy_mode = 1;
        pulse_start();
        for (int i = 0; i < 12; i++) send_req(32'h800 + i*8, 32'h00FF_00FF ^ i, 32'h0012_0034 + i);
        pulse_submit();
        settle();
        for (int i = 0; i < 4; i++) send_req(32'h800 + i*8, (i == 2) ? 32'hFFFF_FFFF : 32'h0000_FFFF, 32'h0000_BEEF + i);
        settle();

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule